// File: doc/BRIEF.md
# Interrupt Flag and Return-Stack Controller

This block collects three interrupt sources for a small 8-bit processor core:

- an external pin, detected on a selectable edge;
- a single-cycle overflow pulse from a timer;
- a change on a four-bit slice of a parallel port.

Each source owns a sticky flag and an enable bit. Both live in one 8-bit control register, which the core reads and writes over a plain register bus. The block drives an interrupt request to the core, gated by a global enable. It also drives a wake request that works while the core sleeps, and that request does not depend on the global enable.

When the core accepts an interrupt, it pulses `take_i` with the current program counter. The block pushes that value onto a small circular hardware stack and clears the global enable. The return-from-interrupt pulse pops the stack and sets the global enable again. Only the program counter is kept. Working registers are left to software.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the control register reads 00h, and `irq_o` and `wake_o` are both 0.
- R2: A register write stores the whole register. The layout is: bit 7 global enable; bit 6 unused and always reads 0; bit 5 timer enable; bit 4 pin enable; bit 3 port enable; bit 2 timer flag; bit 1 pin flag; bit 0 port flag. Read data reflects a write one cycle later.
- R3: The pin flag (bit 1) is set by a rising edge when `ext_rise_sel_i` is 1, and by a falling edge when it is 0. The opposite edge sets nothing. The pin passes through two synchronizer stages, so the flag appears within four clocks of the pin change.
- R4: A one-cycle `tmr_ovf_i` pulse sets the timer flag (bit 2) on the next clock edge.
- R5: The port flag (bit 0) is set whenever `port_hi_i` differs from the snapshot taken at the last `port_rd_i` cycle. The snapshot is 0 after reset. A mismatch keeps setting the flag until the port is read. A change arriving in the read cycle itself may be missed; the snapshot still takes that new value.
- R6: Flags are sticky. Only a register write of 0 clears a flag. A hardware set in the same cycle as a clearing write wins.
- R7: A source's flag is set even while its enable bit is 0.
- R8: `irq_o` is high exactly when the global enable is 1 and at least one flag has its own enable set.
- R9: `wake_o` is high exactly when `sleep_i` is 1 and at least one flag has its enable set, whatever the global enable.
- R10: `take_i` pushes `pc_i` and clears the global enable. `retfie_i` pops the stack and sets the global enable. `ret_pc_o` always shows the most recently pushed, not yet popped value.
- R11: The stack is circular with eight entries. A ninth push overwrites the oldest entry, so eight pops after nine pushes bring `ret_pc_o` back to the ninth value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| ext_rise_sel_i | input | 1 | 1 selects the rising edge, 0 the falling edge |
| tmr_ovf_i | input | 1 | Timer rollover pulse |
| port_hi_i | input | 4 | Watched port bits, synchronous to clk |
| port_rd_i | input | 1 | Core reads the port this cycle |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| sleep_i | input | 1 | Core is in sleep |
| wake_o | output | 1 | Wake request |
| irq_o | output | 1 | Interrupt request to the core |
| take_i | input | 1 | Core is entering the interrupt vector |
| pc_i | input | 13 | Program counter to save |
| retfie_i | input | 1 | Return from interrupt |
| ret_pc_o | output | 13 | Top-of-stack return address |

## Verification
The assertions assume the core never pulses `take_i` and `retfie_i` in the same cycle; one of them checks that assumption. They also assume the port bits and the timer pulse change only between clock edges. The bench keeps within these limits by driving every input just after a falling clock edge and never raising both stack strobes together. Around the port-read window the bench avoids asserting whether the racing change was caught. It instead checks that, after the flag is cleared, the snapshot holds the new value.

// File: rtl/irqc_pkg.sv
// Package: shared bit positions of the interrupt control register.
// Assumes three sources, indexed so that enable = flag index + EN_BASE.
package irqc_pkg;
    localparam int REG_W    = 8;
    localparam int N_SRC    = 3;
    localparam int SRC_PORT = 0;
    localparam int SRC_EXT  = 1;
    localparam int SRC_TMR  = 2;
    localparam int EN_BASE  = 3;
    localparam int GE_BIT   = 7;
endpackage

// File: rtl/irqc_edge_detect.sv
// Synchronizes an asynchronous pin through SYNC_STAGES flops and flags the
// edge picked by rise_sel_i. Assumes SYNC_STAGES >= 2.
module irqc_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_sel_i,
    output logic edge_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the pin through the synchronizer and remember the last stable value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Choose the rising or falling transition of the synchronized pin.
    always_comb begin
        if (rise_sel_i) edge_o = sync_q[SYNC_STAGES-1] & ~prev_q;
        else            edge_o = ~sync_q[SYNC_STAGES-1] & prev_q;
    end
endmodule

// File: rtl/irqc_port_watch.sv
// Compares the watched port bits with a snapshot taken on each port read.
// A mismatch in the read cycle is dropped, because the snapshot absorbs it.
module irqc_port_watch #(
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_i,
    input  logic              rd_i,
    output logic              change_o
);
    logic [PORT_W-1:0] snap_q;

    // Capture the port value whenever the core reads it.
    always_ff @(posedge clk) begin
        if (!rst_n)    snap_q <= '0;
        else if (rd_i) snap_q <= port_i;
    end

    // Report a mismatch outside the read cycle.
    always_comb change_o = (port_i != snap_q) && !rd_i;
endmodule

// File: rtl/irqc_ret_stack.sv
// Circular return-address stack. Assumes DEPTH is a power of two and that
// push and pop are never requested in the same cycle.
module irqc_ret_stack #(
    parameter int PC_W  = 13,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic [PC_W-1:0] push_pc_i,
    input  logic            pop_i,
    output logic [PC_W-1:0] top_o
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [PC_W-1:0]  mem_q [DEPTH];
    logic [PTR_W-1:0] sp_q;
    logic [PTR_W-1:0] top_idx;

    // Advance or retreat the pointer; it wraps on overflow and underflow.
    always_ff @(posedge clk) begin
        if (!rst_n)      sp_q <= '0;
        else if (push_i) sp_q <= sp_q + PTR_W'(1);
        else if (pop_i)  sp_q <= sp_q - PTR_W'(1);
    end

    // Store the pushed address in the slot the pointer names.
    always_ff @(posedge clk) begin
        if (push_i) mem_q[sp_q] <= push_pc_i;
    end

    // The newest entry sits one below the pointer.
    always_comb begin
        top_idx = sp_q - PTR_W'(1);
        top_o   = mem_q[top_idx];
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
// Top-level interrupt controller: sticky flags, enables, global gating,
// the wake request and the return-address stack. Assumes take_i and retfie_i
// are exclusive and port_hi_i is synchronous to clk.
module irq_flag_ctrl
    import irqc_pkg::*;
#(
    parameter int PC_W        = 13,
    parameter int STACK_DEPTH = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PORT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin_i,
    input  logic              ext_rise_sel_i,
    input  logic              tmr_ovf_i,
    input  logic [PORT_W-1:0] port_hi_i,
    input  logic              port_rd_i,
    input  logic              reg_wr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic              sleep_i,
    output logic              wake_o,
    output logic              irq_o,
    input  logic              take_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic              retfie_i,
    output logic [PC_W-1:0]   ret_pc_o
);
    logic             ge_q;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] flg_q;
    logic [N_SRC-1:0] src_set;
    logic             ext_evt;
    logic             port_evt;
    logic             pending;

    irqc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (ext_pin_i),
        .rise_sel_i (ext_rise_sel_i),
        .edge_o     (ext_evt)
    );

    irqc_port_watch #(.PORT_W(PORT_W)) port_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_i   (port_hi_i),
        .rd_i     (port_rd_i),
        .change_o (port_evt)
    );

    irqc_ret_stack #(.PC_W(PC_W), .DEPTH(STACK_DEPTH)) stack_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (take_i),
        .push_pc_i (pc_i),
        .pop_i     (retfie_i),
        .top_o     (ret_pc_o)
    );

    // Gather the per-source set pulses in flag order.
    always_comb begin
        src_set           = '0;
        src_set[SRC_PORT] = port_evt;
        src_set[SRC_EXT]  = ext_evt;
        src_set[SRC_TMR]  = tmr_ovf_i;
    end

    // One sticky flag and one enable per source; a hardware set beats a write.
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flg_q[s] <= 1'b0;
                en_q[s]  <= 1'b0;
            end else begin
                if (src_set[s])    flg_q[s] <= 1'b1;
                else if (reg_wr_i) flg_q[s] <= reg_wdata_i[s];
                if (reg_wr_i)      en_q[s]  <= reg_wdata_i[EN_BASE+s];
            end
        end
    end

    // Global enable: cleared on interrupt entry, set on return, else written.
    always_ff @(posedge clk) begin
        if (!rst_n)        ge_q <= 1'b0;
        else if (take_i)   ge_q <= 1'b0;
        else if (retfie_i) ge_q <= 1'b1;
        else if (reg_wr_i) ge_q <= reg_wdata_i[GE_BIT];
    end

    // Request outputs and register read-back.
    always_comb begin
        pending     = |(flg_q & en_q);
        irq_o       = ge_q & pending;
        wake_o      = sleep_i & pending;
        reg_rdata_o = {ge_q, 1'b0, en_q, flg_q};
    end
endmodule

// File: rtl/irqc_checker.sv
// Checker for irq_flag_ctrl; it watches top-level ports only.
module irqc_checker #(
    parameter int PC_W = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tmr_ovf_i,
    input logic            reg_wr_i,
    input logic [7:0]      reg_rdata_o,
    input logic            sleep_i,
    input logic            wake_o,
    input logic            irq_o,
    input logic            take_i,
    input logic [PC_W-1:0] pc_i,
    input logic            retfie_i,
    input logic [PC_W-1:0] ret_pc_o
);
    // Input assumption: the stack strobes are exclusive.
    assert_no_push_pop_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_i && retfie_i));

    assert_timer_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf_i |=> reg_rdata_o[2]);

    assert_pin_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata_o[1] && !reg_wr_i) |=> reg_rdata_o[1]);

    assert_port_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata_o[0] && !reg_wr_i) |=> reg_rdata_o[0]);

    assert_irq_needs_global_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata_o[7] |-> !irq_o);

    assert_wake_only_asleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_i |-> !wake_o);

    assert_take_clears_global_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> !reg_rdata_o[7]);

    assert_return_sets_global_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (retfie_i && !take_i) |=> reg_rdata_o[7]);

    assert_push_shows_on_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !retfie_i) |=> (ret_pc_o == $past(pc_i)));
endmodule

bind irq_flag_ctrl irqc_checker #(.PC_W(PC_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_ovf_i   (tmr_ovf_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rdata_o (reg_rdata_o),
    .sleep_i     (sleep_i),
    .wake_o      (wake_o),
    .irq_o       (irq_o),
    .take_i      (take_i),
    .pc_i        (pc_i),
    .retfie_i    (retfie_i),
    .ret_pc_o    (ret_pc_o)
);

// File: tb/irq_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a register vector table, then directed tests.
module irq_flag_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_pin_i = 1'b0, ext_rise_sel_i = 1'b1, tmr_ovf_i = 1'b0;
    logic [3:0]  port_hi_i = '0;
    logic        port_rd_i = 1'b0, reg_wr_i = 1'b0, sleep_i = 1'b0;
    logic [7:0]  reg_wdata_i = '0;
    logic [7:0]  reg_rdata_o;
    logic        wake_o, irq_o, take_i = 1'b0, retfie_i = 1'b0;
    logic [12:0] pc_i = '0;
    logic [12:0] ret_pc_o;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    irq_flag_ctrl dut_i (.*);

    // {sleep, wdata, expected read, expected irq, expected wake}  (R2, R8, R9)
    localparam logic [18:0] VEC [10] = '{
        {1'b0, 8'h00, 8'h00, 1'b0, 1'b0},
        {1'b0, 8'hFF, 8'hBF, 1'b1, 1'b0},
        {1'b0, 8'h7F, 8'h3F, 1'b0, 1'b0},
        {1'b1, 8'h3F, 8'h3F, 1'b0, 1'b1},
        {1'b1, 8'h84, 8'h84, 1'b0, 1'b0},
        {1'b1, 8'hA4, 8'hA4, 1'b1, 1'b1},
        {1'b0, 8'h92, 8'h92, 1'b1, 1'b0},
        {1'b0, 8'h89, 8'h89, 1'b1, 1'b0},
        {1'b0, 8'h8A, 8'h8A, 1'b0, 1'b0},
        {1'b0, 8'h40, 8'h00, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        reg_wdata_i = v; reg_wr_i = 1'b1; step(1); reg_wr_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 reg", reg_rdata_o, 8'h00);
        chk("R1 irq", irq_o, 0);
        chk("R1 wake", wake_o, 0);

        for (int i = 0; i < 10; i++) begin
            sleep_i = VEC[i][18];
            wr(VEC[i][17:10]);
            chk("R2 table read", reg_rdata_o, VEC[i][9:2]);
            chk("R8 table irq", irq_o, VEC[i][1]);
            chk("R9 table wake", wake_o, VEC[i][0]);
        end
        sleep_i = 1'b0;

        // R3: edge polarity
        ext_rise_sel_i = 1'b1; ext_pin_i = 1'b1; step(4);
        chk("R3 rise sel rising", reg_rdata_o[1], 1);
        wr(8'h00);
        ext_pin_i = 1'b0; step(4);
        chk("R3 rise sel falling", reg_rdata_o[1], 0);
        ext_rise_sel_i = 1'b0; ext_pin_i = 1'b1; step(4);
        chk("R3 fall sel rising", reg_rdata_o[1], 0);
        ext_pin_i = 1'b0; step(4);
        chk("R3 fall sel falling", reg_rdata_o[1], 1);
        wr(8'h00);

        // R4, R7: timer flag with enable off, then enabled
        tmr_ovf_i = 1'b1; step(1); tmr_ovf_i = 1'b0;
        chk("R4 R7 timer flag", reg_rdata_o, 8'h04);
        chk("R7 no irq", irq_o, 0);
        wr(8'hA4);
        chk("R8 irq", irq_o, 1);

        // R6: sticky, and hardware set beats a clearing write
        step(3);
        chk("R6 sticky", reg_rdata_o, 8'hA4);
        tmr_ovf_i = 1'b1; wr(8'h20); tmr_ovf_i = 1'b0;
        chk("R6 set wins", reg_rdata_o, 8'h24);
        wr(8'h00);
        chk("R6 cleared", reg_rdata_o, 8'h00);

        // R5: port change against the snapshot
        port_hi_i = 4'h5; step(1);
        chk("R5 change sets", reg_rdata_o[0], 1);
        wr(8'h00);
        chk("R5 mismatch persists", reg_rdata_o[0], 1);
        port_rd_i = 1'b1; step(1); port_rd_i = 1'b0;
        wr(8'h00);
        chk("R5 clear after read", reg_rdata_o[0], 0);
        port_hi_i = 4'h9; port_rd_i = 1'b1; step(1); port_rd_i = 1'b0;
        step(1); wr(8'h00); step(2);
        chk("R5 snapshot took racing value", reg_rdata_o[0], 0);

        // R10: push, pop and global enable
        wr(8'h80);
        take_i = 1'b1; pc_i = 13'h0123; step(1); take_i = 1'b0;
        chk("R10 top after push", ret_pc_o, 13'h0123);
        chk("R10 global cleared", reg_rdata_o[7], 0);
        take_i = 1'b1; pc_i = 13'h0456; step(1); take_i = 1'b0;
        chk("R10 top second push", ret_pc_o, 13'h0456);
        retfie_i = 1'b1; step(1); retfie_i = 1'b0;
        chk("R10 top after pop", ret_pc_o, 13'h0123);
        chk("R10 global set", reg_rdata_o[7], 1);
        retfie_i = 1'b1; step(1); retfie_i = 1'b0;

        // R11: nine pushes wrap the eight-entry stack
        for (int k = 1; k <= 9; k++) begin
            take_i = 1'b1; pc_i = 13'(32'h100 + k); step(1);
        end
        take_i = 1'b0;
        for (int k = 0; k <= 8; k++) begin
            chk("R11 wrap order", ret_pc_o, (k < 8) ? 32'h109 - k : 32'h109);
            retfie_i = 1'b1; step(1); retfie_i = 1'b0;
        end

        finish_run();
    end

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end
endmodule